// File: doc/BRIEF.md
# CSR Access Execution Unit

This block carries out the six atomic control-register instructions (write, bit-set and bit-clear, each with a register source or a 5-bit immediate source) against a small machine-level register file. Each cycle in which `opValid` is high, it decodes the 3-bit operation code, the 12-bit register address, the 5-bit source field, the destination index and the current privilege. In that same cycle it returns the register's previous contents for the destination, a destination write enable and an illegal-instruction flag. The register update takes effect at the next rising clock edge.

The file holds a machine scratch register, a scratch register that user mode may access, a read-only identity word, and two cache-control registers, one for instructions and one for data. The enable bit of each cache-control register is also driven straight out to the cache units. The block follows the rules that suppress side effects when the source or destination is register zero. It also treats the cache-enable bit as a field with a single legal value. It sits in the execute stage of a scalar core, which supplies the decoded fields and the source operand.

Top module: `csr_access_unit`

## Requirements
- R1: After reset, both scratch registers read 0 and both cache-control registers read 0x00000001. While `opValid` is low, `rdWe` and `illegal` are 0 and `rdData` is 0.
- R2: `op` uses the instruction's funct3 encoding: low two bits 01 = write, 10 = set, 11 = clear, 00 = not a register operation; bit 2 selects the immediate source. The write form returns the pre-write contents on `rdData` in the same cycle. The source value is stored at the next rising edge and can be read by the next access.
- R3: The set form ORs the source into the register and returns the old contents.
- R4: The clear form clears every register bit that is high in the source and returns the old contents.
- R5: The immediate forms use `rs1Field` zero-extended to 32 bits as the source, in place of `srcVal`.
- R6: The write form with `rdIdx` = 0 does not read: `rdData` is 0 and `rdWe` is 0. The write still takes place.
- R7: The set and clear forms with `rs1Field` = 0 write nothing. This also holds for a read-only address, which then raises no illegal flag and still returns its value.
- R8: An unmapped address or an op whose low bits are 00 raises `illegal`. Whenever `illegal` is high, `rdWe` is 0, `rdData` is 0 and no register changes.
- R9: Address bits [9:8] give the lowest privilege allowed to access the register (`priv`: 0 = user, 1 = supervisor, 3 = machine). Access from a lower privilege raises `illegal`.
- R10: Address bits [11:10] = 11 mark a register as read-only. Any operation that would write it raises `illegal`.
- R11: In the cache-control registers (0x7c0 instruction, 0x7c1 data), bit 0 always reads 1 and bits 31:1 always read 0, whatever is written. `icacheEn` and `dcacheEn` stay 1 at all times.
- R12: `rdWe` is high exactly when the access is legal and `rdIdx` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| op | input | 3 | funct3-encoded operation |
| csrAddr | input | 12 | Register address |
| srcVal | input | 32 | Source register value |
| rs1Field | input | 5 | Source register index, or the immediate in the immediate forms |
| rdIdx | input | 5 | Destination register index |
| priv | input | 2 | Current privilege level |
| rdData | output | 32 | Previous register contents for the destination |
| rdWe | output | 1 | Destination write enable |
| illegal | output | 1 | Illegal-instruction flag |
| icacheEn | output | 1 | Instruction-cache enable |
| dcacheEn | output | 1 | Data-cache enable |

## Verification
A wrong stored value becomes visible at `rdData` on the first later access to that register, which is one cycle after the faulty write in the back-to-back sequences the bench uses. A wrong side-effect or legality decision shows at once on `illegal` or `rdWe` in the cycle of the operation. A write that wrongly took place shows on the next readback. Any corruption of a cache-enable bit appears on `icacheEn` or `dcacheEn` in the cycle after the write that caused it.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 5;

  // Low two funct3 bits; bit 2 picks the immediate source.
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SET   = 2'b10,
    KIND_CLEAR = 2'b11
  } csrKind_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MSCR,
    SEL_USCR,
    SEL_ICEN,
    SEL_DCEN,
    SEL_IDENT
  } csrSel_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    csrSel_e  sel;
    logic     readEn;
    logic     writeEn;
    csrKind_e kind;
    logic     useImm;
  } csrStrobe_t;

endpackage

// File: rtl/csr_unit_ctrl.sv
module csr_unit_ctrl
  import csr_unit_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MSCR_ADDR  = 12'h340,
  parameter logic [ADDR_W-1:0] USCR_ADDR  = 12'h800,
  parameter logic [ADDR_W-1:0] ICEN_ADDR  = 12'h7c0,
  parameter logic [ADDR_W-1:0] DCEN_ADDR  = 12'h7c1,
  parameter logic [ADDR_W-1:0] IDENT_ADDR = 12'hf14
) (
  input  logic              opValid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [IDX_W-1:0]  rs1Field,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [1:0]        priv,
  output csrStrobe_t        strobe,
  output logic              illegal,
  output logic              rdWe
);

  csrKind_e kind;
  csrSel_e  sel;
  logic     wantWrite, wantRead, privOk, roHit, legal;

  always_comb begin
    kind = csrKind_e'(op[1:0]);
    if (csrAddr == MSCR_ADDR)       sel = SEL_MSCR;
    else if (csrAddr == USCR_ADDR)  sel = SEL_USCR;
    else if (csrAddr == ICEN_ADDR)  sel = SEL_ICEN;
    else if (csrAddr == DCEN_ADDR)  sel = SEL_DCEN;
    else if (csrAddr == IDENT_ADDR) sel = SEL_IDENT;
    else                            sel = SEL_NONE;

    // Source zero suppresses the write of set/clear; rd zero suppresses the read of write.
    wantWrite = (kind == KIND_WRITE) || (rs1Field != '0);
    wantRead  = (kind != KIND_WRITE) || (rdIdx != '0);
    privOk    = priv >= csrAddr[9:8];
    roHit     = (csrAddr[11:10] == 2'b11) && wantWrite;
    legal     = opValid && (kind != KIND_NONE) && (sel != SEL_NONE) && privOk && !roHit;
    illegal   = opValid && !legal;

    strobe.sel     = sel;
    strobe.kind    = kind;
    strobe.useImm  = op[2];
    strobe.writeEn = legal && wantWrite;
    strobe.readEn  = legal && wantRead;
    rdWe           = legal && (rdIdx != '0);
  end

endmodule

// File: rtl/csr_unit_dp.sv
module csr_unit_dp
  import csr_unit_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] IDENT_VAL   = 32'h5eed_0001,
  parameter logic        CACHE_LEGAL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IDX_W-1:0]  rs1Field,
  output logic [DATA_W-1:0] rdData,
  output logic              icacheEn,
  output logic              dcacheEn
);

  localparam int NUM_CACHE = 2;

  logic [DATA_W-1:0]    mScr, uScr, srcEff, oldVal, newVal;
  logic [NUM_CACHE-1:0] cacheBit;

  // Maps any requested enable onto the single legal value.
  function automatic logic legalizeEn(input logic req);
    return (req == CACHE_LEGAL) ? req : CACHE_LEGAL;
  endfunction

  always_comb begin
    srcEff = strobe.useImm ? {{(DATA_W-IDX_W){1'b0}}, rs1Field} : srcVal;
    case (strobe.sel)
      SEL_MSCR:  oldVal = mScr;
      SEL_USCR:  oldVal = uScr;
      SEL_ICEN:  oldVal = {{(DATA_W-1){1'b0}}, cacheBit[0]};
      SEL_DCEN:  oldVal = {{(DATA_W-1){1'b0}}, cacheBit[1]};
      SEL_IDENT: oldVal = IDENT_VAL[DATA_W-1:0];
      default:   oldVal = '0;
    endcase
    case (strobe.kind)
      KIND_SET:   newVal = oldVal | srcEff;
      KIND_CLEAR: newVal = oldVal & ~srcEff;
      default:    newVal = srcEff;
    endcase
    rdData = strobe.readEn ? oldVal : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mScr <= '0;
      uScr <= '0;
    end else if (strobe.writeEn) begin
      if (strobe.sel == SEL_MSCR) mScr <= newVal;
      if (strobe.sel == SEL_USCR) uScr <= newVal;
    end
  end

  for (genvar g = 0; g < NUM_CACHE; g++) begin : gCache
    localparam csrSel_e MY_SEL = (g == 0) ? SEL_ICEN : SEL_DCEN;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          cacheBit[g] <= CACHE_LEGAL;
      else if (strobe.writeEn && strobe.sel == MY_SEL)   cacheBit[g] <= legalizeEn(newVal[0]);
    end
  end

  assign icacheEn = cacheBit[0];
  assign dcacheEn = cacheBit[1];

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] MSCR_ADDR  = 12'h340,
  parameter logic [ADDR_W-1:0] USCR_ADDR  = 12'h800,
  parameter logic [ADDR_W-1:0] ICEN_ADDR  = 12'h7c0,
  parameter logic [ADDR_W-1:0] DCEN_ADDR  = 12'h7c1,
  parameter logic [ADDR_W-1:0] IDENT_ADDR = 12'hf14,
  parameter logic [31:0]       IDENT_VAL  = 32'h5eed_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IDX_W-1:0]  rs1Field,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [1:0]        priv,
  output logic [DATA_W-1:0] rdData,
  output logic              rdWe,
  output logic              illegal,
  output logic              icacheEn,
  output logic              dcacheEn
);

  csrStrobe_t strobe;

  csr_unit_ctrl #(
    .MSCR_ADDR(MSCR_ADDR), .USCR_ADDR(USCR_ADDR), .ICEN_ADDR(ICEN_ADDR),
    .DCEN_ADDR(DCEN_ADDR), .IDENT_ADDR(IDENT_ADDR)
  ) uCtrl (
    .opValid(opValid), .op(op), .csrAddr(csrAddr), .rs1Field(rs1Field),
    .rdIdx(rdIdx), .priv(priv), .strobe(strobe), .illegal(illegal), .rdWe(rdWe)
  );

  csr_unit_dp #(
    .DATA_W(DATA_W), .IDENT_VAL(IDENT_VAL), .CACHE_LEGAL(1'b1)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcVal(srcVal), .rs1Field(rs1Field),
    .rdData(rdData), .icacheEn(icacheEn), .dcacheEn(dcacheEn)
  );

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter logic [11:0] IDENT_ADDR = 12'hf14
) (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  op,
  input logic [11:0] csrAddr,
  input logic [4:0]  rs1Field,
  input logic [4:0]  rdIdx,
  input logic [1:0]  priv,
  input logic        rdWe,
  input logic        illegal,
  input logic        icacheEn,
  input logic        dcacheEn
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!rdWe && !illegal));

  assert_no_rd_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && rdIdx == 5'd0) |-> !rdWe);

  assert_ro_zero_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op[1] && rs1Field == 5'd0 && csrAddr == IDENT_ADDR && priv == 2'b11) |-> !illegal);

  assert_illegal_blocks_we_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !rdWe);

  assert_low_priv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && priv < csrAddr[9:8]) |-> illegal);

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op[1:0] == 2'b01 && csrAddr[11:10] == 2'b11) |-> illegal);

  assert_cache_pinned_R11: assert property (@(posedge clk) disable iff (!rstN)
    icacheEn && dcacheEn);

endmodule

bind csr_access_unit csr_unit_chk #(.IDENT_ADDR(IDENT_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .op(op), .csrAddr(csrAddr),
  .rs1Field(rs1Field), .rdIdx(rdIdx), .priv(priv), .rdWe(rdWe),
  .illegal(illegal), .icacheEn(icacheEn), .dcacheEn(dcacheEn)
);

// File: tb/tb_csr_access_unit.sv
`timescale 1ns/1ps
module tb_csr_access_unit;

  localparam logic [31:0] ID_WORD = 32'h1234_0042;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [11:0] csrAddr = 12'h000;
  logic [31:0] srcVal = 32'h0;
  logic [4:0]  rs1Field = 5'd0;
  logic [4:0]  rdIdx = 5'd0;
  logic [1:0]  priv = 2'b11;
  logic [31:0] rdData;
  logic        rdWe, illegal, icacheEn, dcacheEn;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string curTag = "R1";
  logic [31:0] mScrModel = 32'h0;
  logic [31:0] uScrModel = 32'h0;

  always #2.5 clk = ~clk;

  csr_access_unit #(.IDENT_VAL(ID_WORD)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .op(op), .csrAddr(csrAddr),
    .srcVal(srcVal), .rs1Field(rs1Field), .rdIdx(rdIdx), .priv(priv),
    .rdData(rdData), .rdWe(rdWe), .illegal(illegal),
    .icacheEn(icacheEn), .dcacheEn(dcacheEn)
  );

  // Behavioural reference, evaluated away from the active edge.
  always @(negedge clk) begin
    if (!rstN) begin
      mScrModel = 32'h0;
      uScrModel = 32'h0;
    end else begin
      int    kind;
      bit    exists, wr, rd, ill, ok;
      logic [31:0] cur, src, nxt, eData;
      bit    eWe;
      kind = int'(op[1:0]);
      src  = op[2] ? {27'h0, rs1Field} : srcVal;
      exists = 1'b1;
      case (csrAddr)
        12'h340: cur = mScrModel;
        12'h800: cur = uScrModel;
        12'h7c0, 12'h7c1: cur = 32'h1;
        12'hf14: cur = ID_WORD;
        default: begin cur = 32'h0; exists = 1'b0; end
      endcase
      wr  = (kind == 1) || (rs1Field != 0);
      rd  = (kind != 1) || (rdIdx != 0);
      ill = opValid && (kind == 0 || !exists || priv < csrAddr[9:8] ||
                        (csrAddr[11:10] == 2'b11 && wr));
      ok  = opValid && !ill;
      eData = (ok && rd) ? cur : 32'h0;
      eWe   = ok && (rdIdx != 0);
      total++;
      if (rdData !== eData || rdWe !== eWe || illegal !== ill ||
          icacheEn !== 1'b1 || dcacheEn !== 1'b1) begin
        bad++;
        $display("FAIL %s: got data=%h we=%b ill=%b ic=%b dc=%b, expected data=%h we=%b ill=%b ic=1 dc=1",
                 curTag, rdData, rdWe, illegal, icacheEn, dcacheEn, eData, eWe, ill);
      end
      if (ok && wr) begin
        case (kind)
          2: nxt = cur | src;
          3: nxt = cur & ~src;
          default: nxt = src;
        endcase
        if (csrAddr == 12'h340) mScrModel = nxt;
        if (csrAddr == 12'h800) uScrModel = nxt;
      end
    end
  end

  task automatic issue(input logic [2:0] o, input logic [11:0] a, input logic [4:0] r1,
                       input logic [31:0] s, input logic [4:0] rd, input logic [1:0] p,
                       input string tag);
    opValid = 1'b1; op = o; csrAddr = a; rs1Field = r1; srcVal = s; rdIdx = rd; priv = p;
    curTag = tag;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input string tag);
    opValid = 1'b0; curTag = tag;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(3, "R1");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd4, 2'b11, "R1");
    issue(3'b010, 12'h7c0, 5'd0, 32'h0, 5'd4, 2'b11, "R1");
    issue(3'b010, 12'h7c1, 5'd0, 32'h0, 5'd4, 2'b11, "R1");
    // R2 write form, old value back, new value visible next access
    issue(3'b001, 12'h340, 5'd6, 32'hdead_beef, 5'd3, 2'b11, "R2");
    issue(3'b001, 12'h340, 5'd6, 32'h1234_5678, 5'd3, 2'b11, "R2");
    // R3 set
    issue(3'b010, 12'h340, 5'd7, 32'h0f00_00f0, 5'd2, 2'b11, "R3");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd2, 2'b11, "R3");
    // R4 clear
    issue(3'b011, 12'h340, 5'd7, 32'h1200_0008, 5'd2, 2'b11, "R4");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd2, 2'b11, "R4");
    // R5 immediate forms, srcVal must be ignored
    issue(3'b101, 12'h800, 5'h1f, 32'hffff_ffff, 5'd9, 2'b11, "R5");
    issue(3'b111, 12'h800, 5'h03, 32'hffff_ffff, 5'd9, 2'b00, "R5");
    issue(3'b110, 12'h800, 5'h10, 32'h0, 5'd9, 2'b01, "R5");
    issue(3'b110, 12'h800, 5'h00, 32'hffff_ffff, 5'd9, 2'b00, "R5");
    // R6 write with rd zero
    issue(3'b001, 12'h340, 5'd5, 32'ha5a5_a5a5, 5'd0, 2'b11, "R6");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd1, 2'b11, "R6");
    // R7 zero source on set/clear, including read-only register
    issue(3'b010, 12'hf14, 5'd0, 32'hffff_ffff, 5'd8, 2'b11, "R7");
    issue(3'b111, 12'hf14, 5'd0, 32'h0, 5'd8, 2'b11, "R7");
    issue(3'b011, 12'h340, 5'd0, 32'hffff_ffff, 5'd8, 2'b11, "R7");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd8, 2'b11, "R7");
    // R8 unmapped address and non-register op
    issue(3'b001, 12'h345, 5'd3, 32'h0bad_0bad, 5'd4, 2'b11, "R8");
    issue(3'b000, 12'h340, 5'd3, 32'h0, 5'd4, 2'b11, "R8");
    issue(3'b100, 12'h340, 5'd3, 32'h0, 5'd4, 2'b11, "R8");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd4, 2'b11, "R8");
    // R9 privilege
    issue(3'b001, 12'h340, 5'd3, 32'h1111_1111, 5'd4, 2'b00, "R9");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd4, 2'b01, "R9");
    issue(3'b001, 12'h800, 5'd3, 32'h2222_2222, 5'd4, 2'b00, "R9");
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd4, 2'b11, "R9");
    // R10 read-only writes
    issue(3'b001, 12'hf14, 5'd3, 32'h0, 5'd4, 2'b11, "R10");
    issue(3'b110, 12'hf14, 5'd1, 32'h0, 5'd4, 2'b11, "R10");
    issue(3'b011, 12'hf14, 5'd2, 32'hffff_ffff, 5'd0, 2'b11, "R10");
    // R11 cache-control pinning
    issue(3'b001, 12'h7c0, 5'd3, 32'h0, 5'd4, 2'b11, "R11");
    issue(3'b011, 12'h7c1, 5'd3, 32'h1, 5'd4, 2'b11, "R11");
    issue(3'b001, 12'h7c1, 5'd3, 32'hffff_fffe, 5'd4, 2'b11, "R11");
    issue(3'b101, 12'h7c0, 5'h1e, 32'h0, 5'd4, 2'b11, "R11");
    issue(3'b010, 12'h7c0, 5'd0, 32'h0, 5'd4, 2'b11, "R11");
    issue(3'b010, 12'h7c1, 5'd0, 32'h0, 5'd4, 2'b11, "R11");
    // R12 legal set with rd zero: data returned, no destination write
    issue(3'b010, 12'h800, 5'd0, 32'h0, 5'd0, 2'b11, "R12");
    issue(3'b001, 12'h800, 5'd2, 32'h7777_0000, 5'd31, 2'b00, "R12");
    issue(3'b010, 12'h800, 5'd0, 32'h0, 5'd31, 2'b00, "R12");
    idle(2, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule